// File: doc/BRIEF.md
# SD Card Clock Divider and Data Timeout Counter

This block derives the card-side clock of an SD host from the fast core clock. An 11-bit divider setting selects a divisor equal to the setting plus two, so a setting of zero gives half the core rate and the all-ones setting gives the slowest clock. Besides the card clock level, the block emits one-cycle rising and falling strobes in the core clock domain, which the command and data shifters use as clock enables.

How much of the divider setting is used depends on the bus phase. During card identification the full 11-bit value always applies. In data mode only the three least significant bits are used, which limits the data clock to fast rates. A slow-card control overrides this and keeps the full divisor in every mode. A new divisor is adopted only at the start of a card clock period, so each period is complete and has a clean shape.

A companion down-counter measures data timeouts in card clock cycles. A start strobe loads a 32-bit start value. The counter then decrements once per card clock rising strobe and stops at zero, where the timeout flag is raised. The surrounding controller records the expiry as a data-timeout status bit.

Top module: `sdclk_timer`

## Requirements
- R1: The card clock period is (S + 2) core clock cycles, where S is the effective divider setting; S = 0 gives a 2-cycle period and S = 0x7FF gives a 2049-cycle period.
- R2: When `data_mode_i` = 1 (data mode) and `slow_card_i` = 0, only bits [2:0] of `div_val_i` are used, so S = `div_val_i[2:0]` and bits [10:3] have no effect on the period.
- R3: When `data_mode_i` = 0 (identification mode), or when `slow_card_i` = 1 in either mode, the full 11-bit `div_val_i` is used as S.
- R4: Within each period the card clock is high for ceil((S+2)/2) cycles and low for floor((S+2)/2) cycles, so the high phase is one cycle longer for odd divisors.
- R5: A change of `div_val_i`, `data_mode_i` or `slow_card_i` in the middle of a period does not alter that period. The new setting is sampled at the core clock edge that starts the next period.
- R6: `rise_o` is high for exactly the first core cycle of each high phase of `card_clk_o`, and `fall_o` is high for exactly the first core cycle of each low phase. The two are never high together.
- R7: During reset `card_clk_o`, `rise_o`, `fall_o` and `tmo_o` are 0 and the timeout count holds 0xF00000. The first core clock edge after reset is released starts a period with a rising strobe.
- R8: After a start strobe loads value V, the timeout count decrements at each core edge where `rise_o` is high. `tmo_o` rises once V such decrements have occurred and stays high at zero until the next start strobe.
- R9: A start strobe loads the value even when it coincides with a rising strobe, with no decrement in that cycle. A start value of 0 raises `tmo_o` in the next cycle, and a restart mid-count begins a fresh count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_val_i | input | 11 | Divider setting (divisor minus two) |
| tmo_val_i | input | 32 | Timeout start value |
| slow_card_i | input | 1 | Keep the full divisor in every mode |
| data_mode_i | input | 1 | 1 = data mode, 0 = identification mode |
| tmo_start_i | input | 1 | Load the timeout start value |
| card_clk_o | output | 1 | Card clock level |
| rise_o | output | 1 | First core cycle of a card clock high phase |
| fall_o | output | 1 | First core cycle of a card clock low phase |
| tmo_o | output | 1 | Timeout count is zero |

## Verification
The bench measures every period and every high phase against the setting that was present at the edge that opened the period. A design that adopted a new setting mid-period would produce a period with the wrong length, and a design that applied the three-bit data mask in identification mode or under slow-card mode would produce a period that is too short. The extremes, setting 0 and setting 0x7FF, are run in turn with odd divisors. A design that put the extra cycle in the low phase, or that gave a half-rate clock with no low cycle, would fail the high-length check. For the timeout counter, the bench places a start strobe on the same cycle as a rising strobe, loads zero, and restarts mid-count. A design that decremented while loading, or that wrapped below zero, would report a different number of rising strobes before expiry or would drop the flag.

// File: rtl/sdclk_pkg.sv
`timescale 1ns/1ps
package sdclk_pkg;

  typedef enum logic {
    MODE_IDENT = 1'b0,
    MODE_DATA  = 1'b1
  } sdclk_mode_e;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } sdclk_out_t;

endpackage

// File: rtl/sdclk_div_sel.sv
`timescale 1ns/1ps
module sdclk_div_sel #(
  parameter int DIV_W      = 11,
  parameter int DATA_DIV_W = 3
) (
  input  logic [DIV_W-1:0]     div_val_i,
  input  sdclk_pkg::sdclk_mode_e mode_i,
  input  logic                 slow_card_i,
  output logic [DIV_W-1:0]     eff_val_o
);

  logic keep_upper;

  always_comb begin
    keep_upper = (mode_i == sdclk_pkg::MODE_IDENT) | slow_card_i;
  end

  for (genvar b = 0; b < DIV_W; b++) begin : g_bit
    if (b < DATA_DIV_W) begin : g_low
      assign eff_val_o[b] = div_val_i[b];
    end else begin : g_high
      assign eff_val_o[b] = div_val_i[b] & keep_upper;
    end
  end

endmodule

// File: rtl/sdclk_phase_gen.sv
`timescale 1ns/1ps
module sdclk_phase_gen #(
  parameter int DIV_W = 11
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DIV_W-1:0]      eff_val_i,
  output sdclk_pkg::sdclk_out_t out_o
);

  localparam int CNT_W = DIV_W + 1;
  localparam int SUM_W = DIV_W + 2;

  logic [CNT_W-1:0] phase_q, phase_d;
  logic [DIV_W-1:0] lat_q, lat_d;
  logic             lat_en;
  logic [SUM_W-1:0] last_cur;
  logic [SUM_W-1:0] div_nxt;
  logic [SUM_W-1:0] hi_nxt;
  logic             at_end;
  sdclk_pkg::sdclk_out_t out_q, out_d;

  // next-state logic
  always_comb begin
    last_cur = SUM_W'(lat_q) + SUM_W'(1);
    at_end   = (SUM_W'(phase_q) == last_cur);
    lat_en   = at_end;
    lat_d    = eff_val_i;
    phase_d  = at_end ? '0 : (phase_q + CNT_W'(1));
    div_nxt  = SUM_W'(at_end ? eff_val_i : lat_q) + SUM_W'(2);
    hi_nxt   = (div_nxt + SUM_W'(1)) >> 1;
    out_d.lvl  = (SUM_W'(phase_d) < hi_nxt);
    out_d.rise = out_d.lvl & ~out_q.lvl;
    out_d.fall = ~out_d.lvl & out_q.lvl;
  end

  // registers: reset places the counter at the end of a two-cycle period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= CNT_W'(1);
      lat_q   <= '0;
      out_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (lat_en) begin
        lat_q <= lat_d;
      end
      out_q <= out_d;
    end
  end

  assign out_o = out_q;

endmodule

// File: rtl/sdclk_tmo_cnt.sv
`timescale 1ns/1ps
module sdclk_tmo_cnt #(
  parameter int          TMO_W   = 32,
  parameter logic [31:0] TMO_RST = 32'h00F0_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [TMO_W-1:0] load_i,
  output logic             expired_o
);

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             nonzero;

  always_comb begin
    nonzero = (cnt_q != '0);
    cnt_en  = start_i | (tick_i & nonzero);
    cnt_d   = start_i ? load_i : (cnt_q - TMO_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= TMO_W'(TMO_RST);
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = ~nonzero;

endmodule

// File: rtl/sdclk_timer.sv
`timescale 1ns/1ps
module sdclk_timer #(
  parameter int          DIV_W      = 11,
  parameter int          DATA_DIV_W = 3,
  parameter int          TMO_W      = 32,
  parameter logic [31:0] TMO_RST    = 32'h00F0_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_val_i,
  input  logic [TMO_W-1:0] tmo_val_i,
  input  logic             slow_card_i,
  input  logic             data_mode_i,
  input  logic             tmo_start_i,
  output logic             card_clk_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             tmo_o
);

  sdclk_pkg::sdclk_mode_e mode;
  logic [DIV_W-1:0]       eff_val;
  sdclk_pkg::sdclk_out_t  clk_out;

  assign mode = data_mode_i ? sdclk_pkg::MODE_DATA : sdclk_pkg::MODE_IDENT;

  sdclk_div_sel #(
    .DIV_W      (DIV_W),
    .DATA_DIV_W (DATA_DIV_W)
  ) u_sel (
    .div_val_i   (div_val_i),
    .mode_i      (mode),
    .slow_card_i (slow_card_i),
    .eff_val_o   (eff_val)
  );

  sdclk_phase_gen #(
    .DIV_W (DIV_W)
  ) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eff_val_i (eff_val),
    .out_o     (clk_out)
  );

  sdclk_tmo_cnt #(
    .TMO_W   (TMO_W),
    .TMO_RST (TMO_RST)
  ) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (clk_out.rise),
    .start_i   (tmo_start_i),
    .load_i    (tmo_val_i),
    .expired_o (tmo_o)
  );

  assign card_clk_o = clk_out.lvl;
  assign rise_o     = clk_out.rise;
  assign fall_o     = clk_out.fall;

endmodule

// File: rtl/sdclk_timer_chk.sv
`timescale 1ns/1ps
module sdclk_timer_chk #(
  parameter int TMO_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [TMO_W-1:0] tmo_val_i,
  input logic             tmo_start_i,
  input logic             card_clk_o,
  input logic             rise_o,
  input logic             fall_o,
  input logic             tmo_o
);

  assert_strobe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));

  assert_rise_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (card_clk_o && !$past(card_clk_o)));

  assert_fall_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(card_clk_o) |-> fall_o);

  assert_tmo_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_o && !tmo_start_i) |=> tmo_o);

  assert_tmo_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmo_start_i && !rise_o) |=> $stable(tmo_o));

  assert_tmo_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_start_i && (tmo_val_i != '0)) |=> !tmo_o);

endmodule

bind sdclk_timer sdclk_timer_chk #(.TMO_W(TMO_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tmo_val_i   (tmo_val_i),
  .tmo_start_i (tmo_start_i),
  .card_clk_o  (card_clk_o),
  .rise_o      (rise_o),
  .fall_o      (fall_o),
  .tmo_o       (tmo_o)
);

// File: tb/sdclk_timer_tb_top.sv
`timescale 1ns/1ps
module sdclk_timer_tb_top;

  localparam logic [31:0] TMO_RST = 32'h00F0_0000;

  logic        clk;
  logic        rst_n;
  logic [10:0] div;
  logic [31:0] tmo_val;
  logic        slow;
  logic        dmode;
  logic        tstart;
  logic        card_clk, rise_o, fall_o, tmo_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string seg_tag = "";

  sdclk_timer dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .div_val_i   (div),
    .tmo_val_i   (tmo_val),
    .slow_card_i (slow),
    .data_mode_i (dmode),
    .tmo_start_i (tstart),
    .card_clk_o  (card_clk),
    .rise_o      (rise_o),
    .fall_o      (fall_o),
    .tmo_o       (tmo_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int eff_div(input logic [10:0] d, input logic dm, input logic sl);
    if (dm && !sl) return int'(d[2:0]) + 2;
    return int'(d) + 2;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // capture what the design sees at each edge
  logic        cap_start, cap_rise;
  logic [31:0] cap_val;
  int          cap_d;
  string       cap_tag;
  always @(posedge clk) begin
    cap_start <= tstart;
    cap_val   <= tmo_val;
    cap_rise  <= rise_o;
    cap_d     <= eff_div(div, dmode, slow);
    cap_tag   <= (seg_tag != "") ? seg_tag : ((dmode && !slow) ? "R2" : "R3");
  end

  // period, phase, strobe and timeout monitor
  bit          prev_clk;
  bit          have;
  int          cur_d, per_cnt, hi_cnt;
  string       cur_tag;
  logic [31:0] m_tmo;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_clk = 0; have = 0; per_cnt = 0; hi_cnt = 0; cur_d = 2;
      m_tmo = TMO_RST;
    end else begin
      chk(rise_o == (card_clk && !prev_clk), "R6 rise", rise_o, card_clk && !prev_clk);
      chk(fall_o == (!card_clk && prev_clk), "R6 fall", fall_o, !card_clk && prev_clk);
      if (card_clk && !prev_clk) begin
        if (have) chk(per_cnt == cur_d, {cur_tag, " period"}, per_cnt, cur_d);
        cur_d = cap_d; cur_tag = cap_tag; per_cnt = 1; hi_cnt = 1; have = 1;
      end else begin
        per_cnt++;
        if (card_clk) hi_cnt++;
      end
      if (!card_clk && prev_clk && have)
        chk(hi_cnt == (cur_d + 1) / 2, "R4 high phase", hi_cnt, (cur_d + 1) / 2);
      prev_clk = card_clk;
      if (cap_start) m_tmo = cap_val;
      else if (cap_rise && m_tmo != 0) m_tmo = m_tmo - 1;
      chk(tmo_o == (m_tmo == 0), "R8 timeout flag", tmo_o, m_tmo == 0);
    end
  end

  task automatic set_cfg(input logic [10:0] d, input logic dm, input logic sl);
    @(posedge clk); #1;
    div = d; dmode = dm; slow = sl;
  endtask

  task automatic wait_rises(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!rise_o);
    end
  endtask

  // count rising strobes from a load until the flag, return count
  task automatic count_to_expiry(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tmo_o) break;
      if (rise_o) n++;
    end
  endtask

  task automatic tmo_load(input logic [31:0] v);
    @(posedge clk); #1;
    tstart = 1; tmo_val = v;
    @(posedge clk); #1;
    tstart = 0;
  endtask

  initial begin
    int n;
    rst_n = 1; div = 0; tmo_val = 0; slow = 0; dmode = 0; tstart = 0;
    #1 rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(card_clk == 0, "R7 reset clk", card_clk, 0);
    chk(rise_o == 0 && fall_o == 0, "R7 reset strobes", rise_o | fall_o, 0);
    chk(tmo_o == 0, "R7 reset timeout flag", tmo_o, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(rise_o == 0, "R7 no strobe before edge", rise_o, 0);
    @(negedge clk);
    chk(rise_o == 1 && card_clk == 1, "R7 first rise", rise_o, 1);

    // extremes of the setting
    seg_tag = "R1";
    set_cfg(11'd0, 0, 0); wait_rises(4);
    set_cfg(11'h7FF, 0, 0); wait_rises(3);
    set_cfg(11'd1, 0, 0); wait_rises(4);
    // data mode masking and slow-card override
    seg_tag = "";
    set_cfg(11'h7FD, 1, 0); wait_rises(4);
    set_cfg(11'h02D, 1, 1); wait_rises(3);
    set_cfg(11'h02D, 0, 0); wait_rises(3);

    // mid-period change
    seg_tag = "R5";
    set_cfg(11'd20, 0, 0); wait_rises(2);
    repeat (4) @(negedge clk);
    chk(card_clk == 1, "R5 mid high phase", card_clk, 1);
    set_cfg(11'd1, 0, 0); wait_rises(3);
    set_cfg(11'd9, 1, 1); wait_rises(1);
    repeat (7) @(negedge clk);
    set_cfg(11'd6, 1, 0); wait_rises(3);
    seg_tag = "";

    // timeout counter, half-rate card clock
    set_cfg(11'd0, 0, 0); wait_rises(2);
    tmo_load(32'd5);
    count_to_expiry(n);
    chk(n == 5 && tmo_o, "R8 strobes to expiry", n, 5);
    repeat (20) @(negedge clk);
    chk(tmo_o == 1, "R8 stops at zero", tmo_o, 1);
    tmo_load(32'd0);
    @(negedge clk);
    chk(tmo_o == 1, "R9 zero load", tmo_o, 1);
    tmo_load(32'd10);
    wait_rises(4);
    tmo_load(32'd3);
    count_to_expiry(n);
    chk(n == 3, "R9 restart", n, 3);
    // load on a cycle whose edge also carries a rising strobe
    do @(negedge clk); while (!rise_o);
    tstart = 1; tmo_val = 32'd4;
    @(posedge clk); #1 tstart = 0;
    count_to_expiry(n);
    chk(n == 4, "R9 load beats decrement", n, 4);
    set_cfg(11'd4, 1, 1);
    tmo_load(32'd3);
    count_to_expiry(n);
    chk(n == 3, "R8 slower clock", n, 3);

    // constrained random segments
    void'($urandom(32'd20240611));
    for (int s = 0; s < 40; s++) begin
      logic dm, sl;
      logic [10:0] d;
      dm = 1'($urandom);
      sl = 1'($urandom);
      d  = (dm && !sl) ? 11'($urandom) : 11'($urandom % 64);
      set_cfg(d, dm, sl);
      if (($urandom % 3) == 0) begin
        @(posedge clk); #1 tstart = 1; tmo_val = 32'($urandom % 6);
        @(posedge clk); #1 tstart = 0;
      end
      wait_rises(3);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule